// File: doc/BRIEF.md
# Programmable-Priority Bus Arbiter with Parking

This block is the central arbiter of a shared split-transaction bus with up to ten master indexes. Each master raises its own request line. The arbiter hands out a single address-bus grant at a time. The winner is the requesting master that sits in the earliest entry of a programmable list of priority slots. When nobody is requesting, the grant rests on a programmable parking master. That master can then start a transfer without first asking for the bus.

A second, independent output issues data-bus grants. Data grants follow the same order as the address tenures that produced them. Only one data tenure may be open at any time. A configuration bit selects how the data grant is timed against the transfer-start strobe: it can come in the same cycle as the strobe, or at least one cycle later. A second configuration bit hands arbitration to an outside agent, and the block then issues no grants of either kind.

Configuration sits in an 8-bit control register and one 4-bit register per priority slot, all reached through a simple write/read port. While reset is held, the control register loads from a configuration word. Master index codes: 0, 1 and 2 are the high, middle and low request levels of the on-chip communications engine; 6 is the processor core; 7, 8 and 9 are external masters one to three; 3 to 5 and 10 to 15 are reserved.

Top module: `bus_arbiter_top`

## Requirements
- R1: While `rst_n` is low, the control register loads `cfg_word[5:0]`, and its bits 7:6 read as zero. The slots load the order 0,1,2,6,7,8,9,15,15,15 (slot 0 first). All grants are deasserted.
- R2: Register address 0 is the control register. Its bit 5 is the data-grant delay, bit 4 enables external arbitration, and bits 3:0 hold the parking index. Addresses 1..10 select slot 0..9, which uses data bits 3:0. Other addresses read zero and ignore writes. A write takes effect in the following cycle, and the read data is combinational.
- R3: When the arbiter decides, the winner is the requesting master named in the lowest-numbered slot. An index held in no slot, or a reserved code, is never granted through a request.
- R4: A grant won through a request stays unchanged until the transfer-start strobe `ts` is seen while it is asserted. The grant drops in the next cycle. The arbiter decides again in the cycle `aack` is high, and the new grant appears one cycle later.
- R5: When the bus is free and there are no eligible requests, the grant goes to the parking master in the next cycle. A reserved parking code leaves every grant low. A `ts` from the parked master opens a tenure exactly as a requested grant does.
- R6: `abg` is one-hot or zero. Bit i grants master index i.
- R7: With the delay bit at 0, the data grant for a tenure appears in the same cycle as its `ts`, provided no data tenure is open and none is waiting.
- R8: With the delay bit at 1, no data grant is issued in the cycle of the `ts` that opened the tenure. It comes one cycle later at the earliest.
- R9: `dbg` is a one-cycle one-hot pulse. After a pulse, no other pulse comes until the cycle after `dtend` has been seen.
- R10: Up to 4 started tenures wait for their data grants, and the grants are issued in the order the tenures started.
- R11: With external arbitration enabled, `abg` is zero from the next cycle on. `dbg` is zero, and `ts` queues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 8 | Control-register value taken during reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| req | input | 10 | Per-master bus request |
| ts | input | 1 | Transfer-start strobe from the address-grant holder |
| aack | input | 1 | Address tenure completed |
| dtend | input | 1 | Open data tenure completed |
| abg | output | 10 | Address-bus grant, one bit per master |
| dbg | output | 10 | Data-bus grant pulse, one bit per master |

## Verification
The arbiter is driven with several kinds of request pattern. Single requests check index decoding. Paired requests check which slot wins, first with the reset ordering and then with a rewritten one. A request from a master removed from every slot must leave the parked grant in place, and a reserved parking code must leave the bus dark. Bursts of back-to-back transfer starts before any data tenure ends fill the data-grant queue, which separates in-order issue from same-cycle issue and from the one-cycle delayed mode. A long pseudo-random phase mixes requests, strobes, completions, slot rewrites and switches into external mode. In every cycle it compares against a behavioural queue model, which catches wrong decision points and lost or reordered data grants.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int IDXW = 4;
  typedef logic [IDXW-1:0] midx_t;
  typedef enum logic [1:0] {ST_FREE, ST_HELD, ST_ADDR} ast_t;

  // an index can be granted only if it names a real master
  function automatic logic idx_legal(midx_t i, int nmst);
    return (int'(i) < nmst) && !((i >= midx_t'(3)) && (i <= midx_t'(5)));
  endfunction

  // reset ordering: the valid indexes in ascending order, then unused slots
  function automatic midx_t slot_reset(int k);
    if (k < 3) return midx_t'(k);
    else if (k < 7) return midx_t'(k + 3);
    else return '1;
  endfunction
endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs
  import arb_pkg::*;
#(
  parameter int NSLOT = 10,
  parameter int AW    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [7:0]                  cfg_word,
  input  logic                        reg_we,
  input  logic [AW-1:0]               reg_addr,
  input  logic [7:0]                  reg_wdata,
  output logic [7:0]                  reg_rdata,
  output logic                        dgd,
  output logic                        earb,
  output midx_t                       park,
  output logic [NSLOT-1:0][IDXW-1:0]  slots
);
  logic [5:0] ctrl_q;
  midx_t      slot_q [NSLOT];

  always_ff @(posedge clk) begin
    if (!rst_n)                            ctrl_q <= cfg_word[5:0];
    else if (reg_we && reg_addr == '0)     ctrl_q <= reg_wdata[5:0];
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                   slot_q[g] <= slot_reset(g);
      else if (reg_we && reg_addr == AW'(g + 1))    slot_q[g] <= reg_wdata[IDXW-1:0];
    end
    assign slots[g] = slot_q[g];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata = {2'b00, ctrl_q};
    for (int k = 0; k < NSLOT; k++)
      if (reg_addr == AW'(k + 1)) reg_rdata = {{(8-IDXW){1'b0}}, slot_q[k]};
  end

  assign dgd  = ctrl_q[5];
  assign earb = ctrl_q[4];
  assign park = ctrl_q[3:0];

  assert_rsv_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == '0) |-> (reg_rdata[7:6] == 2'b00));
endmodule

// File: rtl/arb_addr_sel.sv
module arb_addr_sel
  import arb_pkg::*;
#(
  parameter int NMST  = 10,
  parameter int NSLOT = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NMST-1:0]             req,
  input  logic                        ts,
  input  logic                        aack,
  input  logic                        earb,
  input  midx_t                       park,
  input  logic [NSLOT-1:0][IDXW-1:0]  slots,
  output logic [NMST-1:0]             abg,
  output logic                        ts_take,
  output midx_t                       gnt_idx
);
  ast_t  st_q;
  logic  gv_q;
  midx_t gi_q;
  logic  [15:0] req_w;
  logic  win_vld, park_vld, arb_now;
  midx_t win_idx;

  assign req_w = {{(16-NMST){1'b0}}, req};

  // scan from the last slot so the lowest-numbered match is kept
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    for (int k = NSLOT - 1; k >= 0; k--) begin
      if (idx_legal(slots[k], NMST) && req_w[slots[k]]) begin
        win_vld = 1'b1;
        win_idx = slots[k];
      end
    end
  end

  assign park_vld = idx_legal(park, NMST);
  assign ts_take  = ts && gv_q && !earb;
  assign arb_now  = (st_q == ST_FREE) || ((st_q == ST_ADDR) && aack);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_FREE;
      gv_q <= 1'b0;
      gi_q <= '0;
    end else if (earb) begin
      st_q <= ST_FREE;
      gv_q <= 1'b0;
    end else if (ts_take) begin
      st_q <= ST_ADDR;
      gv_q <= 1'b0;
    end else if (arb_now) begin
      if (win_vld) begin
        st_q <= ST_HELD;
        gv_q <= 1'b1;
        gi_q <= win_idx;
      end else begin
        st_q <= ST_FREE;
        gv_q <= park_vld;
        gi_q <= park;
      end
    end
  end

  for (genvar g = 0; g < NMST; g++) begin : g_abg
    assign abg[g] = gv_q && (gi_q == midx_t'(g));
  end
  assign gnt_idx = gi_q;

  assert_abg_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(abg));
  assert_grant_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (abg != '0) |-> idx_legal(gi_q, NMST));
  assert_held_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_HELD) && !ts && !earb) |=> $stable(abg));
  assert_ext_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    earb |=> (abg == '0));
endmodule

// File: rtl/arb_data_q.sv
module arb_data_q
  import arb_pkg::*;
#(
  parameter int NMST   = 10,
  parameter int QDEPTH = 4,
  localparam int PW    = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
  localparam int CW    = $clog2(QDEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ts_take,
  input  midx_t           gnt_idx,
  input  logic            dgd,
  input  logic            earb,
  input  logic            dtend,
  output logic [NMST-1:0] dbg
);
  midx_t         mem [QDEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, q_empty, fast_go, pop, push, issue;
  midx_t         issue_idx;

  function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
    return (p == PW'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign q_empty   = (cnt_q == '0);
  assign fast_go   = ts_take && !dgd && q_empty && !busy_q;
  assign pop       = !q_empty && !busy_q && !earb;
  assign push      = ts_take && !fast_go;
  assign issue     = pop || fast_go;
  assign issue_idx = pop ? mem[rd_q] : gnt_idx;

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= gnt_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q   <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (pop)  rd_q <= ptr_next(rd_q);
      if (push) wr_q <= ptr_next(wr_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (issue)      busy_q <= 1'b1;
      else if (dtend) busy_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NMST; g++) begin : g_dbg
    assign dbg[g] = issue && (issue_idx == midx_t'(g));
  end

  assert_dbg_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dbg));
  assert_one_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (dbg == '0));
  assert_delay_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dgd && q_empty) |-> (dbg == '0));
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CW'(QDEPTH)));
  assert_ext_nodata_R11: assert property (@(posedge clk) disable iff (!rst_n)
    earb |-> (dbg == '0));
endmodule

// File: rtl/bus_arbiter_top.sv
module bus_arbiter_top
  import arb_pkg::*;
#(
  parameter int  NMST   = 10,
  parameter int  NSLOT  = 10,
  parameter int  QDEPTH = 4,
  localparam int AW     = $clog2(NSLOT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      cfg_word,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic [NMST-1:0] req,
  input  logic            ts,
  input  logic            aack,
  input  logic            dtend,
  output logic [NMST-1:0] abg,
  output logic [NMST-1:0] dbg
);
  logic                       dgd, earb, ts_take;
  midx_t                      park, gnt_idx;
  logic [NSLOT-1:0][IDXW-1:0] slots;

  arb_cfg_regs #(.NSLOT(NSLOT), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dgd(dgd), .earb(earb), .park(park), .slots(slots)
  );

  arb_addr_sel #(.NMST(NMST), .NSLOT(NSLOT)) u_addr (
    .clk(clk), .rst_n(rst_n), .req(req), .ts(ts), .aack(aack),
    .earb(earb), .park(park), .slots(slots), .abg(abg),
    .ts_take(ts_take), .gnt_idx(gnt_idx)
  );

  arb_data_q #(.NMST(NMST), .QDEPTH(QDEPTH)) u_data (
    .clk(clk), .rst_n(rst_n), .ts_take(ts_take), .gnt_idx(gnt_idx),
    .dgd(dgd), .earb(earb), .dtend(dtend), .dbg(dbg)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (abg == '0));
endmodule

// File: tb/bus_arbiter_top_tb_top.sv
`timescale 1ns/1ps
module bus_arbiter_top_tb_top;
  localparam int NM = 10;
  localparam int NS = 10;
  localparam int QD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_word = 8'hC6;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [NM-1:0] req = '0;
  logic ts = 1'b0, aack = 1'b0, dtend = 1'b0;
  logic [NM-1:0] abg, dbg;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_arbiter_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req(req), .ts(ts), .aack(aack), .dtend(dtend), .abg(abg), .dbg(dbg)
  );

  // behavioural reference model
  int m_ctrl;
  int m_slot [NS];
  int m_st;      // 0 free, 1 held, 2 address tenure open
  bit m_gv;
  int m_gi;
  bit m_busy;
  int dq [$];

  function automatic bit legal(int i);
    return (i >= 0) && (i < NM) && !(i >= 3 && i <= 5);
  endfunction

  task automatic model_reset();
    int order [7] = '{0, 1, 2, 6, 7, 8, 9};
    m_ctrl = cfg_word & 8'h3F;
    for (int k = 0; k < NS; k++) m_slot[k] = (k < 7) ? order[k] : 15;
    m_st = 0; m_gv = 0; m_gi = 0; m_busy = 0;
    dq.delete();
  endtask

  task automatic check(string what, string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", tag, what, $time, act, exp);
    end
  endtask

  // one clock: compare outputs for current inputs, then advance the model
  task automatic tick(string tag);
    int e_abg, e_dbg, e_rd, w;
    bit earb, dgd, tsx, pop, fast;
    #1;
    earb = m_ctrl[4];
    dgd  = m_ctrl[5];
    tsx  = ts && m_gv && !earb;
    e_abg = m_gv ? (1 << m_gi) : 0;
    pop  = !earb && !m_busy && dq.size() > 0;
    fast = tsx && !dgd && dq.size() == 0 && !m_busy;
    e_dbg = pop ? (1 << dq[0]) : (fast ? (1 << m_gi) : 0);
    if (reg_addr == 0) e_rd = m_ctrl;
    else if (reg_addr <= NS) e_rd = m_slot[reg_addr - 1];
    else e_rd = 0;
    check("abg", tag, int'(abg), e_abg);
    check("dbg", tag, int'(dbg), e_dbg);
    check("rdata", tag, int'(reg_rdata), e_rd);
    @(posedge clk);
    if (!rst_n) model_reset();
    else begin
      if (pop) void'(dq.pop_front());
      if (tsx && !fast) dq.push_back(m_gi);
      if (e_dbg != 0) m_busy = 1; else if (dtend) m_busy = 0;
      w = -1;
      for (int k = NS - 1; k >= 0; k--)
        if (legal(m_slot[k]) && req[m_slot[k]]) w = m_slot[k];
      if (earb) begin m_st = 0; m_gv = 0; end
      else if (tsx) begin m_st = 2; m_gv = 0; end
      else if (m_st == 0 || (m_st == 2 && aack)) begin
        if (w >= 0) begin m_st = 1; m_gv = 1; m_gi = w; end
        else begin m_st = 0; m_gv = legal(m_ctrl & 15); m_gi = m_ctrl & 15; end
      end
      if (reg_we) begin
        if (reg_addr == 0) m_ctrl = reg_wdata & 8'h3F;
        else if (reg_addr <= NS) m_slot[reg_addr - 1] = reg_wdata & 15;
      end
    end
    @(negedge clk);
  endtask

  task automatic wr(int a, int d, string tag);
    reg_we = 1; reg_addr = 4'(a); reg_wdata = 8'(d);
    tick(tag);
    reg_we = 0; reg_addr = 0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    tick("R1");                       // reset still held: grants low, ctrl = 0x06
    rst_n = 1;
    for (int a = 0; a < 12; a++) begin reg_addr = 4'(a); tick("R1"); end   // R1/R2 readback
    reg_addr = 0;
    idle(2, "R5");                    // parked on core (index 6)
    // R3: 7 and 1 request, slot order picks 1
    req = 10'b0010000010; tick("R3"); tick("R3");
    ts = 1; tick("R7"); ts = 0;       // R7 same-cycle data grant
    req = 10'b0010000000;
    tick("R4"); tick("R4"); aack = 1; tick("R4"); aack = 0;
    tick("R4"); dtend = 1; tick("R9"); dtend = 0;
    ts = 1; tick("R4"); ts = 0; req = '0; aack = 1; tick("R4"); aack = 0;
    dtend = 1; tick("R9"); dtend = 0; idle(2, "R5");
    // R2/R3: rewrite slot 0 to index 9, remove index 8 from slot 5
    wr(1, 9, "R2"); wr(6, 15, "R2"); wr(12, 3, "R2");
    req = 10'b1000000001; idle(2, "R3");
    ts = 1; tick("R3"); ts = 0; req = 10'b0100000000; aack = 1; tick("R3"); aack = 0;
    idle(3, "R3");                    // index 8 in no slot: stays parked
    dtend = 1; tick("R9"); dtend = 0; req = '0;
    // R5: reserved parking code darkens the bus
    wr(0, 8'h04, "R5"); idle(3, "R5");
    wr(0, 8'h08, "R5"); idle(2, "R5");
    // R8/R10: delayed data grants, several tenures queued before completion
    wr(0, 8'h27, "R8"); idle(2, "R8");
    for (int t = 0; t < 3; t++) begin
      req = (t == 1) ? 10'b0000000001 : 10'b0000000100;
      idle(2, "R10"); ts = 1; tick("R8"); ts = 0; aack = 1; tick("R10"); aack = 0;
    end
    req = '0;
    for (int t = 0; t < 4; t++) begin idle(2, "R10"); dtend = 1; tick("R9"); dtend = 0; end
    // R11: external arbitration
    wr(0, 8'h16, "R11"); req = 10'b1111000111; idle(2, "R11");
    ts = 1; idle(2, "R11"); ts = 0; req = '0;
    wr(0, 8'h06, "R11"); idle(2, "R11");
    // pseudo-random mix (R3 R4 R5 R7 R8 R9 R10 R11)
    for (int c = 0; c < 3000; c++) begin
      int r = $urandom_range(0, 99);
      req = NM'($urandom);
      ts = ($urandom_range(0, 2) == 0) && (dq.size() < QD - 1);
      aack = $urandom_range(0, 2) == 0;
      dtend = m_busy && ($urandom_range(0, 2) == 0);
      reg_we = 0;
      if (r < 3) begin
        reg_we = 1; reg_addr = 0;
        reg_wdata = 8'($urandom_range(0, 255)) & ((r == 0) ? 8'hFF : 8'hEF);
      end else if (r < 6) begin
        reg_we = 1; reg_addr = 4'($urandom_range(1, NS)); reg_wdata = 8'($urandom_range(0, 15));
      end else reg_addr = 4'($urandom_range(0, 15));
      tick("R10");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule